// File: doc/BRIEF.md
# Paged Flash Erase Sequencer

This block clears a region of a serial flash whose page size need not be a power of two. A caller presents a byte offset and a byte length with a one-cycle request. The sequencer first checks that both values are whole multiples of the page size. It then walks the region step by step. At each step it picks either a single-page erase or an eight-page block erase, and sends a four-byte erase command over a byte-level SPI handshake. After the command it reads the device status. It keeps reading, with a fixed pause between reads, until the device reports ready or a timeout window runs out.

The device address is not a linear byte address. It is the page index shifted left by a per-device bit count (`PAGE_SHIFT`). The bit-level serializer sits outside the block and is seen as a request/acknowledge exchange of one byte. Completion is reported with a one-cycle `done_o` pulse, with `err_o` and `tmo_o` qualifying it in the same cycle.

Top module: `paged_erase_seq`

## Requirements
- R1: If `req_offset` or `req_len` is not a whole multiple of `PAGE_SIZE`, the request ends with `done_o` and `err_o` high in the same cycle, and chip select never goes low.
- R2: An aligned request of zero length ends with `done_o` high and `err_o`/`tmo_o` low, with no transaction on the bus.
- R3: A step uses block erase, opcode 0x50, when the current page index has its low three bits at zero and at least 8 pages remain. Every other step uses page erase, opcode 0x81.
- R4: An erase command is exactly four bytes, sent in this order: opcode, address bits 23:16, address bits 15:8, 0x00. The address is the page index shifted left by `PAGE_SHIFT`, reduced to 24 bits.
- R5: After each erase command the block reads status as a two-byte transaction: 0xD7, then a dummy byte. Only bit 7 of the byte received second is used (1 = ready); all other status bits are ignored.
- R6: After a not-ready status, the next status read begins no earlier than `POLL_TICKS*TICK_DIV` cycles after the previous read ended.
- R7: On a ready status the page index advances by 8 after a block erase or by 1 after a page erase, and the remaining count falls by the same amount. When nothing remains, `done_o` pulses for one cycle with no error.
- R8: A not-ready status seen when `TMO_TICKS*TICK_DIV` cycles have passed since the erase command ended aborts the request. `done_o`, `err_o` and `tmo_o` are raised together, and no further command follows. A timeout never fires earlier than that.
- R9: A ready status always completes its step, even when the timeout window has already run out.
- R10: Chip select stays low for the whole of each transaction and goes high between transactions. A byte is requested only while chip select is low.
- R11: A request that arrives while a sequence is running is ignored.
- R12: After reset, chip select is high and `xfer_req`, `done_o`, `err_o` and `tmo_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | One-cycle erase request |
| req_offset | input | OFS_W | Start of the region in bytes |
| req_len | input | OFS_W | Size of the region in bytes |
| done_o | output | 1 | One-cycle pulse when the request ends |
| err_o | output | 1 | Qualifies done_o: request failed |
| tmo_o | output | 1 | Qualifies done_o: failure was a ready timeout |
| spi_cs_n | output | 1 | Flash chip select, active low |
| xfer_req | output | 1 | Byte exchange request to the serializer |
| xfer_tx | output | 8 | Byte to send, held while xfer_req is high |
| xfer_ack | input | 1 | One-cycle acknowledge ending a byte exchange |
| xfer_rx | input | 8 | Byte received, valid with xfer_ack |

## Verification
The ready report and the expiry of the timeout window can both arrive in the same status evaluation. The bench provokes this by running single-page erases against a device model that turns ready at a chosen cycle count after the command. It sweeps that count across the timeout window one cycle at a time. Each outcome is judged against the bench's own record of the last status byte it returned. If that byte said ready, the request must succeed. If the request reports a timeout, that byte must have said not ready and the full window must have elapsed since the command ended.

// File: rtl/erase_seq_pkg.sv
// Shared constants and state type for the paged erase sequencer.
// Assumes a flash that accepts 0x81/0x50 erase commands and reports
// readiness in bit 7 of the byte returned after opcode 0xD7.
package erase_seq_pkg;
    localparam logic [7:0] OP_PAGE_ERASE  = 8'h81;
    localparam logic [7:0] OP_BLOCK_ERASE = 8'h50;
    localparam logic [7:0] OP_STATUS      = 8'hD7;
    localparam int         READY_BIT      = 7;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STEP,
        S_CMD_GO,
        S_CMD_WAIT,
        S_ST_GO,
        S_ST_WAIT,
        S_EVAL,
        S_GAP,
        S_FIN
    } seq_state_e;
endpackage

// File: rtl/erase_step_planner.sv
// Combinational planning for the erase sequencer.
// Converts a byte request into page units and checks its alignment.
// For the current step it decides page vs block erase and forms bits
// 23:8 of the device address. Assumes PAGE_SIZE and BLK_PAGES are
// constants, so the division reduces to a fixed-divisor network.
module erase_step_planner #(
    parameter int OFS_W      = 24,
    parameter int PAGE_SIZE  = 264,
    parameter int PAGE_SHIFT = 9,
    parameter int BLK_PAGES  = 8
) (
    input  logic [OFS_W-1:0] req_offset,
    input  logic [OFS_W-1:0] req_len,
    input  logic [OFS_W-1:0] page,
    input  logic [OFS_W-1:0] rem,
    output logic             aligned,
    output logic [OFS_W-1:0] first_page,
    output logic [OFS_W-1:0] page_cnt,
    output logic             is_block,
    output logic [15:0]      addr_hi
);
    localparam int               BLK_LOG = $clog2(BLK_PAGES);
    localparam logic [OFS_W-1:0] PS_V    = OFS_W'(PAGE_SIZE);
    localparam logic [OFS_W-1:0] BLK_V   = OFS_W'(BLK_PAGES);

    // Request conversion: alignment test and page-unit values.
    always_comb begin
        aligned    = ((req_offset % PS_V) == '0) && ((req_len % PS_V) == '0);
        first_page = req_offset / PS_V;
        page_cnt   = req_len / PS_V;
    end

    // Step choice and device address (page index shifted, bits 23:8).
    always_comb begin
        is_block = (page[BLK_LOG-1:0] == '0) && (rem >= BLK_V);
        addr_hi  = 16'((32'(page) << PAGE_SHIFT) >> 8);
    end
endmodule

// File: rtl/erase_poll_timer.sv
// Poll pause and ready-timeout counters for the erase sequencer.
// The poll counter counts raw cycles up to POLL_TICKS*TICK_DIV after
// poll_clr. The timeout counter counts prescaled ticks after tmo_clr and
// saturates at TMO_TICKS. Both expiry flags stay high until cleared.
module erase_poll_timer #(
    parameter int TICK_DIV   = 8,
    parameter int POLL_TICKS = 3,
    parameter int TMO_TICKS  = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic poll_clr,
    input  logic tmo_clr,
    output logic poll_exp,
    output logic tmo_exp
);
    localparam int POLL_CYC = POLL_TICKS * TICK_DIV;
    localparam int PW       = $clog2(POLL_CYC + 1);
    localparam int DW       = $clog2(TICK_DIV + 1);
    localparam int TW       = $clog2(TMO_TICKS + 1);

    logic [PW-1:0] poll_cnt;
    logic [DW-1:0] pre_cnt;
    logic [TW-1:0] tmo_cnt;
    logic          tick;

    assign tick     = (pre_cnt == DW'(TICK_DIV - 1)) && !tmo_clr;
    assign poll_exp = (poll_cnt == PW'(POLL_CYC));
    assign tmo_exp  = (tmo_cnt == TW'(TMO_TICKS));

    // Pause between status reads, counted in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || poll_clr)          poll_cnt <= '0;
        else if (!poll_exp)              poll_cnt <= poll_cnt + PW'(1);
    end

    // Prescaler producing one tick every TICK_DIV cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || tmo_clr)           pre_cnt <= '0;
        else if (tick)                   pre_cnt <= '0;
        else                             pre_cnt <= pre_cnt + DW'(1);
    end

    // Saturating tick count since the last erase command.
    always_ff @(posedge clk) begin
        if (!rst_n || tmo_clr)           tmo_cnt <= '0;
        else if (tick && !tmo_exp)       tmo_cnt <= tmo_cnt + TW'(1);
    end

    p_tmo_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_exp && !tmo_clr) |=> tmo_exp);
endmodule

// File: rtl/flash_byte_shifter.sv
// Sends one SPI transaction of up to MAX_BYTES bytes through a byte
// request/acknowledge handshake. Chip select drops on start and rises
// with the acknowledge of the last byte. The last received byte is
// captured. Assumes tx_bytes and nbytes stay stable while active.
module flash_byte_shifter #(
    parameter int MAX_BYTES = 4,
    localparam int IW = $clog2(MAX_BYTES + 1),
    localparam int XW = $clog2(MAX_BYTES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [IW-1:0]             nbytes,
    input  logic [MAX_BYTES-1:0][7:0] tx_bytes,
    output logic                      done,
    output logic [7:0]                rx_last,
    output logic                      cs_n,
    output logic                      xfer_req,
    output logic [7:0]                xfer_tx,
    input  logic                      xfer_ack,
    input  logic [7:0]                xfer_rx
);
    logic          active;
    logic [XW-1:0] idx;
    logic          last;

    assign last     = (IW'(idx) == nbytes - IW'(1));
    assign xfer_req = active;
    assign xfer_tx  = tx_bytes[idx];

    // Transaction framing, byte index and capture of the final byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            idx     <= '0;
            cs_n    <= 1'b1;
            done    <= 1'b0;
            rx_last <= '0;
        end else begin
            done <= 1'b0;
            if (!active && start) begin
                active <= 1'b1;
                idx    <= '0;
                cs_n   <= 1'b0;
            end else if (active && xfer_ack) begin
                if (last) begin
                    active  <= 1'b0;
                    cs_n    <= 1'b1;
                    done    <= 1'b1;
                    rx_last <= xfer_rx;
                end else begin
                    idx <= idx + XW'(1);
                end
            end
        end
    end

    p_req_under_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> !cs_n);
    p_cs_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(cs_n, 2));
endmodule

// File: rtl/paged_erase_seq.sv
// Paged flash erase sequencer (top).
// Validates a byte-offset/length request and issues page or block erase
// commands one step at a time. After each command it polls status until
// ready or until the timeout window runs out. Assumes the serializer
// acknowledges every requested byte. Defaults are sized for short
// simulation; set TICK_DIV to one millisecond of cycles for real timing.
module paged_erase_seq
    import erase_seq_pkg::*;
#(
    parameter int OFS_W      = 24,
    parameter int PAGE_SIZE  = 264,
    parameter int PAGE_SHIFT = 9,
    parameter int BLK_PAGES  = 8,
    parameter int TICK_DIV   = 8,
    parameter int POLL_TICKS = 3,
    parameter int TMO_TICKS  = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [OFS_W-1:0] req_offset,
    input  logic [OFS_W-1:0] req_len,
    output logic             done_o,
    output logic             err_o,
    output logic             tmo_o,
    output logic             spi_cs_n,
    output logic             xfer_req,
    output logic [7:0]       xfer_tx,
    input  logic             xfer_ack,
    input  logic [7:0]       xfer_rx
);
    localparam int               BLK_LOG = $clog2(BLK_PAGES);
    localparam logic [OFS_W-1:0] BLK_V   = OFS_W'(BLK_PAGES);

    seq_state_e       state;
    logic [OFS_W-1:0] page, rem;
    logic             blk;
    logic [15:0]      addr_q;
    logic             fail, tmo_flag;

    logic             aligned, is_block;
    logic [OFS_W-1:0] first_page, page_cnt;
    logic [15:0]      addr_hi;
    logic             poll_exp, tmo_exp, poll_clr, tmo_clr;
    logic             sh_start, sh_done;
    logic [2:0]       sh_nbytes;
    logic [3:0][7:0]  sh_bytes;
    logic [7:0]       sh_rx;
    logic             st_ready;
    logic             status_rest_unused;

    assign st_ready           = sh_rx[READY_BIT];
    assign status_rest_unused = ^sh_rx[READY_BIT-1:0];

    erase_step_planner #(
        .OFS_W(OFS_W), .PAGE_SIZE(PAGE_SIZE),
        .PAGE_SHIFT(PAGE_SHIFT), .BLK_PAGES(BLK_PAGES)
    ) u_plan (
        .req_offset(req_offset), .req_len(req_len),
        .page(page), .rem(rem),
        .aligned(aligned), .first_page(first_page), .page_cnt(page_cnt),
        .is_block(is_block), .addr_hi(addr_hi)
    );

    erase_poll_timer #(
        .TICK_DIV(TICK_DIV), .POLL_TICKS(POLL_TICKS), .TMO_TICKS(TMO_TICKS)
    ) u_timer (
        .clk(clk), .rst_n(rst_n),
        .poll_clr(poll_clr), .tmo_clr(tmo_clr),
        .poll_exp(poll_exp), .tmo_exp(tmo_exp)
    );

    flash_byte_shifter #(.MAX_BYTES(4)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .start(sh_start), .nbytes(sh_nbytes), .tx_bytes(sh_bytes),
        .done(sh_done), .rx_last(sh_rx),
        .cs_n(spi_cs_n), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
        .xfer_ack(xfer_ack), .xfer_rx(xfer_rx)
    );

    // Transaction content: erase command or status read, by state.
    always_comb begin
        if (state == S_CMD_GO || state == S_CMD_WAIT) begin
            sh_nbytes = 3'd4;
            sh_bytes  = {8'h00, addr_q[7:0], addr_q[15:8],
                         blk ? OP_BLOCK_ERASE : OP_PAGE_ERASE};
        end else begin
            sh_nbytes = 3'd2;
            sh_bytes  = {8'h00, 8'h00, 8'h00, OP_STATUS};
        end
    end

    // Single-cycle controls towards the shifter and the timers.
    always_comb begin
        sh_start = (state == S_CMD_GO) || (state == S_ST_GO);
        tmo_clr  = (state == S_CMD_WAIT) && sh_done;
        poll_clr = (state == S_EVAL);
    end

    // Completion outputs, all qualified by the finish state.
    always_comb begin
        done_o = (state == S_FIN);
        err_o  = (state == S_FIN) && fail;
        tmo_o  = (state == S_FIN) && tmo_flag;
    end

    // Step sequencing: validate, issue, poll, advance or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            page     <= '0;
            rem      <= '0;
            blk      <= 1'b0;
            addr_q   <= '0;
            fail     <= 1'b0;
            tmo_flag <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    tmo_flag <= 1'b0;
                    if (aligned) begin
                        page  <= first_page;
                        rem   <= page_cnt;
                        fail  <= 1'b0;
                        state <= S_STEP;
                    end else begin
                        fail  <= 1'b1;
                        state <= S_FIN;
                    end
                end
                S_STEP: if (rem == '0) begin
                    state <= S_FIN;
                end else begin
                    blk    <= is_block;
                    addr_q <= addr_hi;
                    state  <= S_CMD_GO;
                end
                S_CMD_GO:   state <= S_CMD_WAIT;
                S_CMD_WAIT: if (sh_done) state <= S_ST_GO;
                S_ST_GO:    state <= S_ST_WAIT;
                S_ST_WAIT:  if (sh_done) state <= S_EVAL;
                S_EVAL: if (st_ready) begin
                    page  <= page + (blk ? BLK_V : OFS_W'(1));
                    rem   <= rem - (blk ? BLK_V : OFS_W'(1));
                    state <= S_STEP;
                end else if (tmo_exp) begin
                    fail     <= 1'b1;
                    tmo_flag <= 1'b1;
                    state    <= S_FIN;
                end else begin
                    state <= S_GAP;
                end
                S_GAP:   if (poll_exp) state <= S_ST_GO;
                S_FIN:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    p_misalign_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && req_valid && !aligned) |=> (done_o && err_o));
    p_block_rule_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CMD_GO && blk) |-> (page[BLK_LOG-1:0] == '0 && rem >= BLK_V));
    p_poll_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ST_GO && $past(state) == S_GAP) |-> $past(poll_exp));
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_tmo_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_o |-> (tmo_exp && err_o));
endmodule

// File: tb/tb_paged_erase_seq.sv
`timescale 1ns/1ps
module tb_paged_erase_seq;
    localparam int OFS_W      = 24;
    localparam int PS         = 264;
    localparam int SHIFT      = 9;
    localparam int TICK_DIV   = 8;
    localparam int POLL_TICKS = 3;
    localparam int TMO_TICKS  = 40;
    localparam int POLL_CYC   = POLL_TICKS * TICK_DIV;
    localparam int TMO_CYC    = TMO_TICKS * TICK_DIV;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [OFS_W-1:0] req_offset = '0;
    logic [OFS_W-1:0] req_len = '0;
    logic             done_o, err_o, tmo_o, spi_cs_n, xfer_req;
    logic [7:0]       xfer_tx;
    logic             xfer_ack = 1'b0;
    logic [7:0]       xfer_rx = 8'h00;

    paged_erase_seq #(
        .OFS_W(OFS_W), .PAGE_SIZE(PS), .PAGE_SHIFT(SHIFT), .BLK_PAGES(8),
        .TICK_DIV(TICK_DIV), .POLL_TICKS(POLL_TICKS), .TMO_TICKS(TMO_TICKS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_offset(req_offset), .req_len(req_len),
        .done_o(done_o), .err_o(err_o), .tmo_o(tmo_o),
        .spi_cs_n(spi_cs_n), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
        .xfer_ack(xfer_ack), .xfer_rx(xfer_rx)
    );

    always #2 clk = ~clk;

    int   checks = 0, errors = 0, cyc = 0;
    bit   wd_hit = 0;
    // device-model and expectation state
    logic [7:0] bb [0:7];
    int   bcnt = 0, x_start = 0, ncmd = 0, cmd_end = 0, last_st_end = 0;
    int   e_page = 0, e_rem = 0, busy_n = 0, busy_left = 0, t_ready = 0;
    bit   in_x = 0, time_mode = 0, last_ready = 0, st_prev = 0, cs_seen = 0;
    bit   got_done = 0, got_err = 0, got_tmo = 0;
    int   done_cyc = 0;

    task automatic chk(input bit ok, input string rq, input longint act,
                       input longint exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] status_byte();
        bit rdy;
        if (time_mode) rdy = (cyc - cmd_end) >= t_ready;
        else begin
            rdy = (busy_left == 0);
            if (busy_left > 0) busy_left--;
        end
        last_ready = rdy;
        return rdy ? 8'hAC : 8'h7F;   // other bits deliberately noisy (R5)
    endfunction

    task automatic finish_xfer();
        if (bb[0] == 8'hD7) begin
            chk(bcnt == 2, "R5", bcnt, 2, "status transaction length");
            last_st_end = cyc;
            st_prev = 1;
        end else begin
            int  exp_op, exp_addr;
            bit  exp_blk;
            ncmd++;
            chk(bcnt == 4, "R10", bcnt, 4, "erase transaction length");
            if (e_rem <= 0) begin
                chk(0, "R7", bb[0], 0, "command after region exhausted");
            end else begin
                exp_blk  = (e_page % 8 == 0) && (e_rem >= 8);
                exp_op   = exp_blk ? 8'h50 : 8'h81;
                exp_addr = (e_page << SHIFT) & 24'hFFFFFF;
                chk(bb[0] == exp_op, "R3", bb[0], exp_op, "erase opcode");
                chk({bb[1], bb[2], bb[3]} == {exp_addr[23:8], 8'h00}, "R4",
                    {bb[1], bb[2], bb[3]}, {exp_addr[23:8], 8'h00}, "address bytes");
                e_page += exp_blk ? 8 : 1;
                e_rem  -= exp_blk ? 8 : 1;
            end
            cmd_end   = cyc;
            st_prev   = 0;
            busy_left = busy_n;
        end
    endtask

    // Serializer and flash model, driven away from the active edge.
    initial begin
        forever begin
            logic [7:0] rx;
            @(negedge clk);
            cyc++;
            if (done_o) begin
                got_done = 1; got_err = err_o; got_tmo = tmo_o; done_cyc = cyc;
            end
            if (!spi_cs_n) cs_seen = 1;
            if (xfer_ack) begin
                xfer_ack = 1'b0;
            end else if (xfer_req) begin
                if (spi_cs_n) chk(0, "R10", 1, 0, "byte requested with chip select high");
                if (bcnt == 0) x_start = cyc;
                if (bcnt < 8) bb[bcnt] = xfer_tx;
                rx = 8'hFF;
                if (bcnt == 0 && xfer_tx == 8'hD7 && st_prev && !last_ready)
                    chk(x_start - last_st_end >= POLL_CYC, "R6",
                        x_start - last_st_end, POLL_CYC, "pause between status reads");
                if (bcnt == 1 && bb[0] == 8'hD7) rx = status_byte();
                xfer_rx  = rx;
                xfer_ack = 1'b1;
                bcnt++;
                in_x = 1;
            end
            if (spi_cs_n && in_x) begin
                finish_xfer();
                in_x = 0;
                bcnt = 0;
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            if (cyc > 190000) begin
                wd_hit = 1;
                chk(0, "WATCHDOG", cyc, 190000, "run did not finish");
                summary();
                $finish;
            end
        end
    end

    task automatic start_req(input int ofs, input int len);
        @(negedge clk);
        got_done = 0; got_err = 0; got_tmo = 0; ncmd = 0; cs_seen = 0;
        last_ready = 0; st_prev = 0;
        e_page = ofs / PS; e_rem = len / PS;
        req_offset = OFS_W'(ofs); req_len = OFS_W'(len); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!got_done && n < 8000 && !wd_hit) begin
            @(posedge clk);
            n++;
        end
        if (!got_done) chk(0, tag, 0, 1, "done never seen");
        @(posedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(spi_cs_n && !xfer_req && !done_o && !err_o && !tmo_o, "R12",
            {spi_cs_n, xfer_req, done_o, err_o, tmo_o}, 5'b10000, "reset outputs");
        rst_n = 1'b1;
        repeat (3) @(posedge clk);

        // Sweep of start page and page count, device ready at once.
        busy_n = 0; time_mode = 0;
        for (int sp = 0; sp < 12; sp++) begin
            for (int np = 0; np < 20; np++) begin
                start_req(sp * PS, np * PS);
                wait_done(np == 0 ? "R2" : "R7");
                chk(got_done && !got_err && !got_tmo, np == 0 ? "R2" : "R7",
                    {got_err, got_tmo}, 0, "clean completion");
                chk(e_rem == 0, "R7", e_rem, 0, "pages left unerased");
                if (np == 0) chk(!cs_seen, "R2", cs_seen, 0, "bus activity on empty request");
            end
        end

        // Misaligned offset, misaligned length, misaligned with zero length.
        start_req(5 * PS + 3, 2 * PS);  wait_done("R1");
        chk(got_err && !got_tmo, "R1", {got_err, got_tmo}, 2'b10, "offset misaligned");
        chk(!cs_seen, "R1", cs_seen, 0, "bus touched on bad offset");
        start_req(0, PS + 7);           wait_done("R1");
        chk(got_err && !got_tmo, "R1", {got_err, got_tmo}, 2'b10, "length misaligned");
        chk(!cs_seen, "R1", cs_seen, 0, "bus touched on bad length");
        start_req(1, 0);                wait_done("R1");
        chk(got_err, "R1", got_err, 1, "offset misaligned, empty length");

        // Busy device: several not-ready polls per step.
        busy_n = 4;
        start_req(6 * PS, 11 * PS);     wait_done("R6");
        chk(got_done && !got_err && e_rem == 0, "R6", e_rem, 0, "polled erase completes");
        busy_n = 0;

        // Device never ready: timeout aborts after the full window.
        time_mode = 1; t_ready = 1000000;
        start_req(8 * PS, 8 * PS);      wait_done("R8");
        chk(got_err && got_tmo, "R8", {got_err, got_tmo}, 2'b11, "timeout flags");
        chk(done_cyc - cmd_end >= TMO_CYC, "R8", done_cyc - cmd_end, TMO_CYC, "timeout too early");
        chk(ncmd == 1, "R8", ncmd, 1, "commands before abort");
        cs_seen = 0;
        repeat (80) @(posedge clk);
        chk(!cs_seen, "R8", cs_seen, 0, "bus activity after abort");

        // Ready time swept across the timeout boundary.
        for (int tr = TMO_CYC - 40; tr <= TMO_CYC + 40; tr++) begin
            t_ready = tr;
            start_req(3 * PS, PS);      wait_done("R9");
            chk(!(last_ready && got_err), "R9", got_err, 0, "ready report overridden");
            chk(got_err || last_ready, "R9", last_ready, 1, "success without ready");
            if (got_err)
                chk(got_tmo && done_cyc - cmd_end >= TMO_CYC, "R8",
                    done_cyc - cmd_end, TMO_CYC, "early or unflagged timeout");
        end
        time_mode = 0;

        // Second request during a run is ignored.
        busy_n = 2;
        start_req(0, 10 * PS);
        repeat (30) @(posedge clk);
        @(negedge clk);
        req_offset = OFS_W'(3 * PS); req_len = OFS_W'(PS); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done("R11");
        chk(!got_err && e_rem == 0 && ncmd == 3, "R11", ncmd, 3, "commands of first request");
        got_done = 0;
        repeat (60) @(posedge clk);
        chk(!got_done && ncmd == 3 && spi_cs_n, "R11", ncmd, 3, "stray second sequence");

        summary();
        $finish;
    end
endmodule